// File: doc/BRIEF.md
# Dual-CPU Peripheral Clock Gating Controller

This block decides, every cycle, which peripheral clocks run in a system with two processors that share a pool of peripherals. Each processor claims peripherals through its own allocation bits and says, through its own low-power bits, whether a claimed peripheral keeps its clock while that processor sleeps. Each processor reports its power state as run, sleep or stop. A peripheral's clock runs while at least one claiming processor still needs it. A peripheral in the always-on domain may also be kept clocked by its autonomous bit, whatever the processor states.

The same allocation data guards the two switchable power domains. Domain 0 belongs to CPU0 and domain 1 to CPU1. A request to switch a domain off is refused while the other processor has claimed a peripheral inside that domain and the other processor's own domain is still on. Some resources are hard-wired as claimed by one processor, or by both, through parameter masks that no input can clear.

Top module: `periph_clk_arbiter`

## Requirements
- R1: While rstN is low, every bit of clkEn and offGrant is 0.
- R2: State codes on cpu0State and cpu1State are 2'b00 run, 2'b01 sleep, 2'b10 stop and 2'b11 (reserved) handled as stop. A CPU requests the clock of peripheral p when p is allocated to it and the CPU is in run, or is in sleep with its low-power bit for p set. A CPU in stop requests nothing.
- R3: clkEn[p] is the OR of the two CPU requests and the autonomous request. It is registered: a change of any input shows on clkEn after the next rising clock edge and not before.
- R4: Peripheral p belongs to the domain coded in periphDomain[2p+1:2p]: 0 is domain 0, 1 is domain 1, 2 is the always-on domain, 3 is no switchable domain. autoEn[p] keeps the clock of p on only when its code is 2 and has no effect for any other code.
- R5: Bits set in parameter IMPL_CPU0 count as allocated to CPU0, bits in IMPL_CPU1 as allocated to CPU1, and bits in IMPL_BOTH as allocated to both, regardless of the allocation inputs (defaults 8'h03, 8'h0C, 8'h80).
- R6: offGrant[d] is 1 the cycle after a cycle where offReq[d] is 1 and no veto exists for domain d.
- R7: Domain 0 is vetoed while some peripheral coded 0 is allocated to CPU1 and offGrant[1] is 0; domain 1 is vetoed while some peripheral coded 1 is allocated to CPU0 and offGrant[0] is 0. Once the other domain is granted off, the veto lifts.
- R8: offGrant[d] falls on the first rising edge after offReq[d] falls or a veto for domain d appears.
- R9: A low-power bit has no effect while its CPU is in run or in stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpu0Alloc | input | NUM_PERIPH | CPU0 allocation bit per peripheral |
| cpu1Alloc | input | NUM_PERIPH | CPU1 allocation bit per peripheral |
| cpu0LpEn | input | NUM_PERIPH | CPU0 keep-clock-in-sleep bit per peripheral |
| cpu1LpEn | input | NUM_PERIPH | CPU1 keep-clock-in-sleep bit per peripheral |
| autoEn | input | NUM_PERIPH | Autonomous clock bit per peripheral |
| cpu0State | input | 2 | CPU0 power state |
| cpu1State | input | 2 | CPU1 power state |
| periphDomain | input | 2*NUM_PERIPH | Domain code per peripheral |
| offReq | input | 2 | Power-off request per switchable domain |
| clkEn | output | NUM_PERIPH | Registered clock enable per peripheral |
| offGrant | output | 2 | Registered power-off grant per switchable domain |

## Verification
The hardest situation to reach is the lifting of a veto through the other domain's grant: domain 1 must be held vetoed by a CPU0 claim while domain 0 is first granted off, and only then may domain 1 follow one cycle later. Random stimulus rarely lines up both requests, a foreign claim and a free domain 0, so a directed sequence walks through refusal, grant, veto-driven drop and the two-step grant in order. Random cycles then mix all state codes, domain codes and masks against a bench model that tracks the expected grants.

// File: rtl/pca_pkg.sv
package pca_pkg;

  localparam int NUM_DOM = 2;
  localparam int DOM_W   = 2;

  typedef enum logic [1:0] {
    CPU_RUN   = 2'b00,
    CPU_SLEEP = 2'b01,
    CPU_STOP  = 2'b10,
    CPU_RSVD  = 2'b11
  } cpuState_e;

  localparam logic [DOM_W-1:0] DOM_PRI  = 2'd0;
  localparam logic [DOM_W-1:0] DOM_SEC  = 2'd1;
  localparam logic [DOM_W-1:0] DOM_AON  = 2'd2;
  localparam logic [DOM_W-1:0] DOM_NONE = 2'd3;

  // Strobes from control to datapath: which CPU may request clocks now.
  typedef struct packed {
    logic run0;
    logic sleep0;
    logic run1;
    logic sleep1;
  } pcaStrobe_t;

endpackage

// File: rtl/pca_ctrl.sv
module pca_ctrl
  import pca_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         cpu0State,
  input  logic [1:0]         cpu1State,
  input  logic [NUM_DOM-1:0] offReq,
  input  logic [NUM_DOM-1:0] foreignAlloc,
  output pcaStrobe_t         stb,
  output logic [NUM_DOM-1:0] offGrant
);

  cpuState_e st0, st1;
  assign st0 = cpuState_e'(cpu0State);
  assign st1 = cpuState_e'(cpu1State);

  // Reserved code falls through to "no request", same as stop.
  always_comb begin
    stb        = '0;
    stb.run0   = (st0 == CPU_RUN);
    stb.sleep0 = (st0 == CPU_SLEEP);
    stb.run1   = (st1 == CPU_RUN);
    stb.sleep1 = (st1 == CPU_SLEEP);
  end

  logic [NUM_DOM-1:0] veto;
  logic [NUM_DOM-1:0] grantNext;

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    localparam int OTHER = NUM_DOM - 1 - d;
    // The other CPU holds a claim here and its own domain is still on.
    assign veto[d]      = foreignAlloc[d] & ~offGrant[OTHER];
    assign grantNext[d] = offReq[d] & ~veto[d];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) offGrant <= '0;
    else       offGrant <= grantNext;
  end

endmodule

// File: rtl/pca_datapath.sv
module pca_datapath
  import pca_pkg::*;
#(
  parameter int                    NUM_PERIPH = 8,
  parameter logic [NUM_PERIPH-1:0] IMPL_CPU0  = '0,
  parameter logic [NUM_PERIPH-1:0] IMPL_CPU1  = '0,
  parameter logic [NUM_PERIPH-1:0] IMPL_BOTH  = '0,
  localparam int                   MAP_W      = DOM_W * NUM_PERIPH
)(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_PERIPH-1:0] cpu0Alloc,
  input  logic [NUM_PERIPH-1:0] cpu1Alloc,
  input  logic [NUM_PERIPH-1:0] cpu0LpEn,
  input  logic [NUM_PERIPH-1:0] cpu1LpEn,
  input  logic [NUM_PERIPH-1:0] autoEn,
  input  logic [MAP_W-1:0]      periphDomain,
  input  pcaStrobe_t            stb,
  output logic [NUM_PERIPH-1:0] clkEn,
  output logic [NUM_DOM-1:0]    foreignAlloc
);

  logic [NUM_PERIPH-1:0] eff0, eff1;
  logic [NUM_PERIPH-1:0] inPri, inSec;
  logic [NUM_PERIPH-1:0] clkNext;

  // Hard-wired claims cannot be dropped by the allocation inputs.
  assign eff0 = cpu0Alloc | IMPL_CPU0 | IMPL_BOTH;
  assign eff1 = cpu1Alloc | IMPL_CPU1 | IMPL_BOTH;

  for (genvar p = 0; p < NUM_PERIPH; p++) begin : g_per
    logic [DOM_W-1:0] domCode;
    logic want0, want1, wantAuto;

    assign domCode  = periphDomain[DOM_W*p +: DOM_W];
    assign inPri[p] = (domCode == DOM_PRI);
    assign inSec[p] = (domCode == DOM_SEC);

    assign want0    = eff0[p] & (stb.run0 | (stb.sleep0 & cpu0LpEn[p]));
    assign want1    = eff1[p] & (stb.run1 | (stb.sleep1 & cpu1LpEn[p]));
    assign wantAuto = autoEn[p] & (domCode == DOM_AON);

    assign clkNext[p] = want0 | want1 | wantAuto;
  end

  // Registered enables keep the gate control free of decode glitches.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) clkEn <= '0;
    else       clkEn <= clkNext;
  end

  // Domain 0 cares about CPU1 claims, domain 1 about CPU0 claims.
  assign foreignAlloc[0] = |(inPri & eff1);
  assign foreignAlloc[1] = |(inSec & eff0);

endmodule

// File: rtl/periph_clk_arbiter.sv
module periph_clk_arbiter
  import pca_pkg::*;
#(
  parameter int                    NUM_PERIPH = 8,
  parameter logic [NUM_PERIPH-1:0] IMPL_CPU0  = 8'h03,
  parameter logic [NUM_PERIPH-1:0] IMPL_CPU1  = 8'h0C,
  parameter logic [NUM_PERIPH-1:0] IMPL_BOTH  = 8'h80
)(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_PERIPH-1:0]       cpu0Alloc,
  input  logic [NUM_PERIPH-1:0]       cpu1Alloc,
  input  logic [NUM_PERIPH-1:0]       cpu0LpEn,
  input  logic [NUM_PERIPH-1:0]       cpu1LpEn,
  input  logic [NUM_PERIPH-1:0]       autoEn,
  input  logic [1:0]                  cpu0State,
  input  logic [1:0]                  cpu1State,
  input  logic [2*NUM_PERIPH-1:0]     periphDomain,
  input  logic [1:0]                  offReq,
  output logic [NUM_PERIPH-1:0]       clkEn,
  output logic [1:0]                  offGrant
);

  pcaStrobe_t         stb;
  logic [NUM_DOM-1:0] foreignAlloc;

  pca_ctrl ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .cpu0State    (cpu0State),
    .cpu1State    (cpu1State),
    .offReq       (offReq),
    .foreignAlloc (foreignAlloc),
    .stb          (stb),
    .offGrant     (offGrant)
  );

  pca_datapath #(
    .NUM_PERIPH (NUM_PERIPH),
    .IMPL_CPU0  (IMPL_CPU0),
    .IMPL_CPU1  (IMPL_CPU1),
    .IMPL_BOTH  (IMPL_BOTH)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .cpu0Alloc    (cpu0Alloc),
    .cpu1Alloc    (cpu1Alloc),
    .cpu0LpEn     (cpu0LpEn),
    .cpu1LpEn     (cpu1LpEn),
    .autoEn       (autoEn),
    .periphDomain (periphDomain),
    .stb          (stb),
    .clkEn        (clkEn),
    .foreignAlloc (foreignAlloc)
  );

endmodule

// File: rtl/pca_checker.sv
module pca_checker #(
  parameter int                    NUM_PERIPH = 8,
  parameter logic [NUM_PERIPH-1:0] IMPL_CPU0  = '0,
  parameter logic [NUM_PERIPH-1:0] IMPL_CPU1  = '0,
  parameter logic [NUM_PERIPH-1:0] IMPL_BOTH  = '0
)(
  input logic                    clk,
  input logic                    rstN,
  input logic [NUM_PERIPH-1:0]   cpu0Alloc,
  input logic [NUM_PERIPH-1:0]   cpu1Alloc,
  input logic [NUM_PERIPH-1:0]   cpu0LpEn,
  input logic [NUM_PERIPH-1:0]   cpu1LpEn,
  input logic [NUM_PERIPH-1:0]   autoEn,
  input logic [1:0]              cpu0State,
  input logic [1:0]              cpu1State,
  input logic [2*NUM_PERIPH-1:0] periphDomain,
  input logic [1:0]              offReq,
  input logic [NUM_PERIPH-1:0]   clkEn,
  input logic [1:0]              offGrant
);

  logic [NUM_PERIPH-1:0] codeAon, codePri, codeSec, own0, own1, expReq;
  always_comb begin
    own0 = cpu0Alloc | IMPL_CPU0 | IMPL_BOTH;
    own1 = cpu1Alloc | IMPL_CPU1 | IMPL_BOTH;
    for (int p = 0; p < NUM_PERIPH; p++) begin
      codeAon[p] = (periphDomain[2*p +: 2] == 2'd2);
      codePri[p] = (periphDomain[2*p +: 2] == 2'd0);
      codeSec[p] = (periphDomain[2*p +: 2] == 2'd1);
      expReq[p]  = (own0[p] && (cpu0State == 2'b00 || (cpu0State == 2'b01 && cpu0LpEn[p])))
                || (own1[p] && (cpu1State == 2'b00 || (cpu1State == 2'b01 && cpu1LpEn[p])))
                || (autoEn[p] && codeAon[p]);
    end
  end

  logic veto0, veto1;
  assign veto0 = (|(codePri & own1)) && !offGrant[1];
  assign veto1 = (|(codeSec & own0)) && !offGrant[0];

  // R1
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (clkEn == '0 && offGrant == '0));

  // R3
  a_r3_clk_follows: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> clkEn == $past(expReq));

  // R2
  a_r2_both_stopped: assert property (@(posedge clk) disable iff (!rstN)
    (cpu0State[1] && cpu1State[1] && !(|(autoEn & codeAon))) |=> clkEn == '0);

  // R6
  a_r6_grant_dom0: assert property (@(posedge clk) disable iff (!rstN)
    (offReq[0] && !veto0) |=> offGrant[0]);
  a_r6_grant_dom1: assert property (@(posedge clk) disable iff (!rstN)
    (offReq[1] && !veto1) |=> offGrant[1]);

  // R7
  a_r7_veto_dom0: assert property (@(posedge clk) disable iff (!rstN)
    veto0 |=> !offGrant[0]);
  a_r7_veto_dom1: assert property (@(posedge clk) disable iff (!rstN)
    veto1 |=> !offGrant[1]);

  // R8
  a_r8_drop_no_req: assert property (@(posedge clk) disable iff (!rstN)
    (offReq != 2'b11) |=> (offGrant & ~$past(offReq)) == 2'b00);

endmodule

bind periph_clk_arbiter pca_checker #(
  .NUM_PERIPH (NUM_PERIPH),
  .IMPL_CPU0  (IMPL_CPU0),
  .IMPL_CPU1  (IMPL_CPU1),
  .IMPL_BOTH  (IMPL_BOTH)
) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .cpu0Alloc    (cpu0Alloc),
  .cpu1Alloc    (cpu1Alloc),
  .cpu0LpEn     (cpu0LpEn),
  .cpu1LpEn     (cpu1LpEn),
  .autoEn       (autoEn),
  .cpu0State    (cpu0State),
  .cpu1State    (cpu1State),
  .periphDomain (periphDomain),
  .offReq       (offReq),
  .clkEn        (clkEn),
  .offGrant     (offGrant)
);

// File: tb/periph_clk_arbiter_tb_top.sv
`timescale 1ns/1ps
module periph_clk_arbiter_tb_top;

  localparam int         N     = 8;
  localparam logic [7:0] IMP0  = 8'h03;
  localparam logic [7:0] IMP1  = 8'h0C;
  localparam logic [7:0] IMPB  = 8'h80;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0]   a0, a1, l0, l1, au;
  logic [1:0]     s0, s1, req;
  logic [2*N-1:0] dom;
  logic [N-1:0]   clkEn;
  logic [1:0]     offGrant;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [1:0] expGrant = 2'b00;

  always #5 clk = ~clk;

  periph_clk_arbiter dut_i (
    .clk(clk), .rstN(rstN),
    .cpu0Alloc(a0), .cpu1Alloc(a1), .cpu0LpEn(l0), .cpu1LpEn(l1),
    .autoEn(au), .cpu0State(s0), .cpu1State(s1),
    .periphDomain(dom), .offReq(req),
    .clkEn(clkEn), .offGrant(offGrant)
  );

  function automatic logic wants(logic own, logic [1:0] st, logic lp);
    return own && (st == 2'b00 || (st == 2'b01 && lp));
  endfunction

  function automatic logic [N-1:0] modelClk();
    logic [N-1:0] r;
    for (int p = 0; p < N; p++)
      r[p] = wants(a0[p] | IMP0[p] | IMPB[p], s0, l0[p])
          || wants(a1[p] | IMP1[p] | IMPB[p], s1, l1[p])
          || (au[p] && dom[2*p +: 2] == 2'd2);
    return r;
  endfunction

  function automatic logic [1:0] modelGrant();
    logic f0, f1;
    f0 = 1'b0; f1 = 1'b0;
    for (int p = 0; p < N; p++) begin
      if (dom[2*p +: 2] == 2'd0 && (a1[p] | IMP1[p] | IMPB[p])) f0 = 1'b1;
      if (dom[2*p +: 2] == 2'd1 && (a0[p] | IMP0[p] | IMPB[p])) f1 = 1'b1;
    end
    return {req[1] && !(f1 && !expGrant[0]), req[0] && !(f0 && !expGrant[1])};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Inputs are set at a falling edge; one rising edge later the outputs are compared.
  task automatic step(string tag);
    logic [N-1:0] ec;
    logic [1:0]   eg;
    ec = modelClk();
    eg = modelGrant();
    @(posedge clk);
    @(negedge clk);
    expGrant = eg;
    check({tag, " clkEn"}, 32'(clkEn), 32'(ec));
    check({tag, " offGrant"}, 32'(offGrant), 32'(eg));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    a0 = '0; a1 = '0; l0 = '0; l1 = '0; au = '0;
    s0 = 2'b10; s1 = 2'b10; req = 2'b11; dom = {N{2'd2}};
    s0 = 2'b00;
    repeat (3) @(negedge clk);
    // R1: outputs stay clear while reset is held, despite live requests
    check("R1 reset clkEn", 32'(clkEn), 32'h0);
    check("R1 reset offGrant", 32'(offGrant), 32'h0);
    rstN = 1'b1;
    req = 2'b00;
    step("R1 release");

    // R5: only hard-wired claims, CPU0 runs
    s0 = 2'b00; s1 = 2'b10;
    step("R5 cpu0 run");
    check("R5 cpu0 implicit", 32'(clkEn), 32'h83);
    s0 = 2'b10; s1 = 2'b00;
    step("R5 cpu1 run");
    check("R5 cpu1 implicit", 32'(clkEn), 32'h8C);

    // R2: state codes
    a0 = 8'h10; s0 = 2'b00; s1 = 2'b10;
    step("R2 run");
    check("R2 run value", 32'(clkEn), 32'h93);
    s0 = 2'b11;
    step("R2 reserved as stop");
    check("R2 reserved value", 32'(clkEn), 32'h00);
    s0 = 2'b01; l0 = 8'h00;
    step("R2 sleep no lp");
    check("R2 sleep no lp value", 32'(clkEn), 32'h00);
    l0 = 8'h10;
    step("R9 sleep lp");
    check("R9 sleep lp value", 32'(clkEn), 32'h10);
    s0 = 2'b00; l0 = 8'h00;
    step("R9 run ignores lp");
    check("R9 run lp clear value", 32'(clkEn), 32'h93);
    s0 = 2'b10; l0 = 8'hFF;
    step("R9 stop ignores lp");
    check("R9 stop lp set value", 32'(clkEn), 32'h00);
    l0 = 8'h00;

    // Both CPUs own one peripheral; CPU1 running keeps it alive
    a0 = 8'h20; a1 = 8'h20; s0 = 2'b10; s1 = 2'b00;
    step("R2 shared");
    check("R2 shared value", 32'(clkEn), 32'hAC);

    // R4: autonomous bit only in the always-on domain
    a0 = '0; a1 = '0; s0 = 2'b10; s1 = 2'b10; au = 8'h30;
    dom = {N{2'd2}}; dom[2*5 +: 2] = 2'd0;
    step("R4 auto");
    check("R4 auto value", 32'(clkEn), 32'h10);
    dom[2*4 +: 2] = 2'd3;
    step("R4 auto code3");
    check("R4 auto code3 value", 32'(clkEn), 32'h00);
    au = '0;

    // R3: registered output does not move before the edge
    s0 = 2'b00;
    #1;
    check("R3 no early change", 32'(clkEn), 32'h00);
    step("R3 after edge");
    check("R3 after edge value", 32'(clkEn), 32'h83);

    // Power-off sequence: p0,p1 domain 0; p2..p4 domain 1; others always-on
    dom = {N{2'd2}};
    dom[0 +: 2] = 2'd0; dom[2 +: 2] = 2'd0;
    dom[4 +: 2] = 2'd1; dom[6 +: 2] = 2'd1; dom[8 +: 2] = 2'd1;
    req = 2'b00; a0 = '0; a1 = '0;
    step("R8 idle");
    a0 = 8'h10; req = 2'b10;
    step("R7 refused");
    check("R7 refused value", 32'(offGrant), 32'h0);
    a0 = 8'h00;
    step("R6 granted");
    check("R6 granted value", 32'(offGrant), 32'h2);
    a0 = 8'h10;
    step("R8 veto drops");
    check("R8 veto drop value", 32'(offGrant), 32'h0);
    req = 2'b11;
    step("R7 dom0 first");
    check("R7 dom0 first value", 32'(offGrant), 32'h1);
    step("R7 veto lifted");
    check("R7 veto lifted value", 32'(offGrant), 32'h3);
    req = 2'b01;
    step("R8 req drop");
    check("R8 req drop value", 32'(offGrant), 32'h1);

    // R3: random mix checked against the bench model
    for (int i = 0; i < 400; i++) begin
      a0  = N'($urandom) & N'($urandom);
      a1  = N'($urandom) & N'($urandom);
      l0  = N'($urandom);
      l1  = N'($urandom);
      au  = N'($urandom) & N'($urandom);
      s0  = 2'($urandom);
      s1  = 2'($urandom);
      dom = (2*N)'($urandom);
      if ($urandom % 4 != 0) req = 2'($urandom);
      step("R3 random");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule